// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold DMA and Interrupts

This block sits between a register bus and the serial shifter of an audio port. It holds a transmit queue and a receive queue of 16-bit samples, each 32 entries deep. Software, or a DMA engine, writes outgoing samples and reads incoming ones through a small word-addressed register bus. The serial side removes transmit words and inserts receive words one per cycle, using strobes. Each queue has a 6-bit level threshold that paces a DMA request line, so the DMA engine refills or drains the queue only when needed.

Level flags and two error events are recorded as sticky bits in an event register. The error events are a transmit underrun (a pop while the transmit queue is empty, which yields a zero sample) and a receive overflow (a push into a full receive queue, whose word is dropped). Each sticky bit has its own enable, and a global enable gates the interrupt output. Software clears sticky bits by writing ones to a clear register.

Register map, by word index on `bus_addr_i`:
- 0: control.
- 1: transmit data, write only.
- 2: receive data, read pops.
- 3: event enable.
- 4: event status.
- 5: level status.
- 6: event clear, write-one-to-clear.

Top module: `audio_fifo_irq`

## Requirements
- R1: After reset, the level status, event status and control registers read 0, and `irq_o`, `tx_dma_req_o` and `rx_dma_req_o` are low.
- R2: Control bit 1 enables the transmit queue. A write to index 1 with bit 16 set queues bits 15:0, and a write with bit 16 clear is ignored. Queued words come out on `tx_word_o` in write order, one per `tx_pop_i` cycle.
- R3: Control bit 0 enables the receive queue. `rx_push_i` stores `rx_word_i`. A read of index 2 returns the oldest word in bits 15:0 with bit 16 set, and removes it from the queue.
- R4: The level status register (index 5) holds:
  - the transmit count in bits 19:14 and the receive count in bits 9:4;
  - receive empty, almost-empty (count ≤ 4), almost-full (count ≥ 28) and full flags in bits 0, 1, 2 and 3;
  - the same four transmit flags in bits 10, 11, 12 and 13.
  Flags read 0 while their queue is disabled.
- R5: `tx_dma_req_o` is high exactly when control bits 3 and 1 are set and the transmit count is at or below control bits 18:13.
- R6: `rx_dma_req_o` is high exactly when control bits 2 and 0 are set, the receive count is non-zero, and the count is at or above control bits 12:7.
- R7: A transmit pop from an empty enabled queue gives `tx_word_o` = 0 and sets event bit 10. A receive push into a full queue drops the word, leaves the count at 32 and sets event bit 5.
- R8: A transmit write into a full queue is dropped and sets event bit 11. A receive read of an empty enabled queue returns 0 (bit 16 clear) and sets event bit 4.
- R9: Event bits 5:0 (receive) and 11:6 (transmit) record empty, almost-empty, almost-full, full, underrun and overflow, in that order. Event status bit 13 is the OR of the event bits masked by the matching enable bits 12:0. `irq_o` equals enable bit 14 ANDed with bit 13.
- R10: Writing ones to index 6 clears the matching event bits one cycle later. A condition still present in that cycle sets its bit again.
- R11: Event bit 12 is set by any serial-side word transfer, whether an accepted transmit pop or an accepted receive push.
- R12: Clearing a queue's enable bit empties that queue. While disabled, the queue ignores pushes and pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from `bus_addr_i` |
| tx_pop_i | input | 1 | Serial side takes a transmit word |
| tx_word_o | output | DW | Head of transmit queue, 0 when empty |
| rx_push_i | input | 1 | Serial side offers a receive word |
| rx_word_i | input | DW | Receive word |
| tx_dma_req_o | output | 1 | Transmit refill request |
| rx_dma_req_o | output | 1 | Receive drain request |
| irq_o | output | 1 | Interrupt |

## Verification
Read data and `tx_word_o` are combinational, so the bench samples them 1 ns after it drives the strobe, before the edge that applies the pop. Counts, flags, DMA requests, event bits and `irq_o` change at the edge that takes the stimulus. The bench therefore reads them at the falling edge after that edge. A clear write and a still-true level condition meet at the same edge, so the expected value after a clear keeps the level bits that stay true. A scoreboard queue holds every accepted sample, and a monitor compares each pop or valid read against its head at the cycle it occurs.

// File: rtl/audio_fifo_irq.sv
module audio_fifo_irq #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int AGAP  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [2:0]    bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_word_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_word_i,
  output logic          tx_dma_req_o,
  output logic          rx_dma_req_o,
  output logic          irq_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = 6;
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
  localparam logic [CW-1:0] AE_N   = CW'(AGAP);
  localparam logic [CW-1:0] AF_N   = CW'(DEPTH - AGAP);
  localparam logic [2:0] A_CTRL = 3'd0, A_TXD = 3'd1, A_RXD = 3'd2, A_IEN = 3'd3,
                         A_IST  = 3'd4, A_FST = 3'd5, A_CLR = 3'd6;

  logic [31:0]   ctrl_q;
  logic [14:0]   ien_q;
  logic [12:0]   stat_q;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire tx_en = ctrl_q[1];
  wire rx_en = ctrl_q[0];
  wire [CW-1:0] tx_thr = ctrl_q[18:13];
  wire [CW-1:0] rx_thr = ctrl_q[12:7];

  wire tx_empty = (tx_cnt == '0);
  wire rx_empty = (rx_cnt == '0);
  wire tx_full  = (tx_cnt == FULL_N);
  wire rx_full  = (rx_cnt == FULL_N);

  wire tx_wr_hit = bus_wr_i && bus_addr_i == A_TXD && bus_wdata_i[16] && tx_en;
  wire tx_push   = tx_wr_hit && !tx_full;
  wire tx_ovf    = tx_wr_hit && tx_full;
  wire tx_pop    = tx_pop_i && tx_en && !tx_empty;
  wire tx_starve = tx_pop_i && tx_en && tx_empty;

  wire rx_rd_hit = bus_rd_i && bus_addr_i == A_RXD && rx_en;
  wire rx_pop    = rx_rd_hit && !rx_empty;
  wire rx_starve = rx_rd_hit && rx_empty;
  wire rx_push   = rx_push_i && rx_en && !rx_full;
  wire rx_ovf    = rx_push_i && rx_en && rx_full;

  wire [3:0] tx_flags = {4{tx_en}} & {tx_full, tx_cnt >= AF_N, tx_cnt <= AE_N, tx_empty};
  wire [3:0] rx_flags = {4{rx_en}} & {rx_full, rx_cnt >= AF_N, rx_cnt <= AE_N, rx_empty};

  wire [12:0] ev = {tx_pop | rx_push,
                    tx_ovf, tx_starve, tx_flags[3], tx_flags[2], tx_flags[1], tx_flags[0],
                    rx_ovf, rx_starve, rx_flags[3], rx_flags[2], rx_flags[1], rx_flags[0]};
  wire [12:0] clr = (bus_wr_i && bus_addr_i == A_CLR) ? bus_wdata_i[12:0] : 13'd0;
  wire pending = |(stat_q & ien_q[12:0]);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (bus_wr_i && bus_addr_i == A_CTRL) ctrl_q <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == A_IEN)  ien_q  <= {bus_wdata_i[14], 1'b0, bus_wdata_i[12:0]};
      stat_q <= (stat_q & ~clr) | ev;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !tx_en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !rx_en) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata_i[DW-1:0];
    if (rx_push) rx_mem[rx_wp] <= rx_word_i;
  end

  assign tx_word_o    = tx_empty ? '0 : tx_mem[tx_rp];
  assign tx_dma_req_o = ctrl_q[3] && tx_en && (tx_cnt <= tx_thr);
  assign rx_dma_req_o = ctrl_q[2] && rx_en && !rx_empty && (rx_cnt >= rx_thr);
  assign irq_o        = ien_q[14] && pending;

  always_comb begin
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o = ctrl_q;
      A_RXD:   bus_rdata_o = rx_empty ? 32'd0 : (32'(rx_mem[rx_rp]) | 32'h1_0000);
      A_IEN:   bus_rdata_o = 32'(ien_q);
      A_IST:   bus_rdata_o = {18'd0, pending, stat_q};
      A_FST:   bus_rdata_o = {12'd0, tx_cnt, tx_flags, rx_cnt, rx_flags};
      default: bus_rdata_o = 32'd0;
    endcase
  end
endmodule

module afi_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_wr_i,
  input logic        bus_rd_i,
  input logic [2:0]  bus_addr_i,
  input logic        tx_pop_i,
  input logic        rx_push_i,
  input logic [15:0] tx_word_o,
  input logic        tx_dma_req_o,
  input logic        irq_o,
  input logic [5:0]  tx_cnt,
  input logic [5:0]  rx_cnt,
  input logic [31:0] ctrl_q,
  input logic [14:0] ien_q,
  input logic [12:0] stat_q
);
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt <= 6'(DEPTH)) && (rx_cnt <= 6'(DEPTH)));

  assert_starve_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_i && tx_cnt == 6'd0) |-> tx_word_o == 16'd0);

  assert_starve_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_i && ctrl_q[1] && tx_cnt == 6'd0) |=> stat_q[10]);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && ctrl_q[0] && rx_cnt == 6'(DEPTH) && !bus_wr_i && !(bus_rd_i && bus_addr_i == 3'd2))
    |=> rx_cnt == 6'(DEPTH));

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q[14] && ((ien_q[12:0] & stat_q) != 13'd0)));

  assert_txdma_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o |-> (tx_cnt <= ctrl_q[18:13]));

  assert_off_empty_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[0] |=> rx_cnt == 6'd0);
endmodule

bind audio_fifo_irq afi_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .bus_wr_i, .bus_rd_i, .bus_addr_i, .tx_pop_i, .rx_push_i,
  .tx_word_o, .tx_dma_req_o, .irq_o, .tx_cnt, .rx_cnt, .ctrl_q, .ien_q, .stat_q
);

// File: tb/sim_audio_fifo_irq.sv
module sim_audio_fifo_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_pop = 1'b0, rx_push = 1'b0;
  logic [15:0] tx_word, rx_word = '0;
  logic tx_dma, rx_dma, irq;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] txq[$];
  logic [15:0] rxq[$];

  always #2 clk = ~clk;

  audio_fifo_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_pop_i(tx_pop), .tx_word_o(tx_word), .rx_push_i(rx_push), .rx_word_i(rx_word),
    .tx_dma_req_o(tx_dma), .rx_dma_req_o(rx_dma), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tx_put(input logic [15:0] d, input bit accepted);
    if (accepted) txq.push_back(d);
    wr(3'd1, 32'h1_0000 | 32'(d));
  endtask

  task automatic tx_take();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic rx_put(input logic [15:0] d, input bit accepted);
    if (accepted) rxq.push_back(d);
    @(negedge clk); rx_push = 1'b1; rx_word = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (tx_pop) chk("R2 tx order", 32'(tx_word), 32'(txq.size() != 0 ? txq.pop_front() : 16'd0));
    if (bus_rd && bus_addr == 3'd2 && bus_rdata[16])
      chk("R3 rx order", bus_rdata, 32'h1_0000 | 32'(rxq.size() != 0 ? rxq.pop_front() : 16'hxxxx));
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  localparam logic [31:0] CTRL_ON = (32'd4 << 13) | (32'd8 << 7) | 32'hF;

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(3'd5, d); chk("R1 level status", d, 0);
    rd(3'd4, d); chk("R1 event status", d, 0);
    rd(3'd0, d); chk("R1 control", d, 0);
    chk("R1 outputs", {29'd0, irq, tx_dma, rx_dma}, 0);

    wr(3'd0, CTRL_ON);
    rd(3'd5, d); chk("R4 empty flags", d, 32'h0C03);
    chk("R5 tx dma at 0", 32'(tx_dma), 1);
    chk("R6 rx dma empty", 32'(rx_dma), 0);

    for (int i = 0; i < 6; i++) tx_put(16'hA100 + 16'(i), 1'b1);
    wr(3'd1, 32'h0000_BEEF);  // no valid bit: ignored (R2)
    rd(3'd5, d); chk("R2 R4 tx count 6", d, (32'd6 << 14) | 32'h3);
    chk("R5 tx dma above thr", 32'(tx_dma), 0);
    tx_take(); tx_take();
    chk("R5 tx dma at thr", 32'(tx_dma), 1);
    for (int i = 0; i < 4; i++) tx_take();
    tx_take();  // underrun, monitor expects 0 (R7)
    rd(3'd4, d); chk("R7 underrun bit", 32'(d[10]), 1);

    wr(3'd6, 32'h1FFF);
    rd(3'd4, d); chk("R10 clear keeps live levels", d, 32'h00C3);

    rx_put(16'h5001, 1'b1);
    rd(3'd4, d); chk("R11 word transfer bit", 32'(d[12]), 1);
    wr(3'd3, (32'd1 << 14) | (32'd1 << 12));
    chk("R9 irq on", 32'(irq), 1);
    rd(3'd4, d); chk("R9 pending bit", 32'(d[13]), 1);
    wr(3'd6, 32'd1 << 12);
    chk("R9 R10 irq off after clear", 32'(irq), 0);
    wr(3'd3, 32'd1 << 12);
    rx_put(16'h5002, 1'b1);
    rd(3'd4, d); chk("R9 pending without global", 32'(d[13]), 1);
    chk("R9 irq gated", 32'(irq), 0);

    for (int i = 0; i < 5; i++) rx_put(16'h5003 + 16'(i), 1'b1);
    chk("R6 rx dma below thr", 32'(rx_dma), 0);
    rx_put(16'h5008, 1'b1);
    chk("R6 rx dma at thr", 32'(rx_dma), 1);
    for (int i = 0; i < 8; i++) rd(3'd2, d);
    rd(3'd2, d); chk("R8 empty rx read", d, 0);
    rd(3'd4, d); chk("R8 rx underrun bit", 32'(d[4]), 1);

    for (int i = 0; i < 32; i++) rx_put(16'h7000 + 16'(i), 1'b1);
    rd(3'd5, d); chk("R4 rx full", d, 32'h0E0C);
    rx_put(16'hDEAD, 1'b0);
    rd(3'd5, d); chk("R7 rx count stays 32", d, 32'h0E0C);
    rd(3'd4, d); chk("R7 rx overflow bit", 32'(d[5]), 1);
    for (int i = 0; i < 32; i++) rd(3'd2, d);
    chk("R3 rx drained", 32'(rxq.size()), 0);

    for (int i = 0; i < 32; i++) tx_put(16'h3000 + 16'(i), 1'b1);
    rd(3'd5, d); chk("R4 tx full", d, 32'h0008_3003);
    tx_put(16'hBAD0, 1'b0);
    rd(3'd4, d); chk("R8 tx overflow bit", 32'(d[11]), 1);
    for (int i = 0; i < 32; i++) tx_take();
    chk("R2 tx drained", 32'(txq.size()), 0);

    for (int i = 0; i < 3; i++) tx_put(16'h9000 + 16'(i), 1'b1);
    wr(3'd0, CTRL_ON & ~32'hA);
    txq.delete();
    rd(3'd5, d); chk("R12 disable empties tx", d, 32'h3);
    tx_put(16'h9999, 1'b0);
    rd(3'd5, d); chk("R12 disabled ignores write", d, 32'h3);
    wr(3'd0, CTRL_ON);
    rd(3'd5, d); chk("R12 re-enabled empty", d, 32'h0C03);
    tx_take();

    repeat (2) @(negedge clk);
    summary();
  end
endmodule